// File: doc/BRIEF.md
# Stacked Read-Clear Interrupt Status Register

This block gathers eight bus-controller interrupt conditions into one 8-bit status word that a CPU reads. Each condition arrives as a single-cycle pulse and sets its status bit, which stays set until a read. The read returns the word and clears exactly the bits it returned. A separate enable mask decides which status bits drive the combined interrupt request. The mask never stops a bit from latching.

Conditions that fire while status is already held, or while a read is being settled, are not merged into the visible word. They go into a second pending level. After a read, the block waits a fixed gap of cycles, then moves the pending bits up into the visible word. Back-to-back reads therefore see the conditions in stacked order, and nothing is lost when an event lands on the same cycle as a read.

Bit 7 has two meanings, picked by a mode input. In initiator mode it flags a bus phase mismatch. The engine pulses that flag at the moment the target raises REQ. In target mode it flags that the initiator raised ATN.

A three-state machine controls the block:
- IDLE: status and pending level are both empty.
- HOLD: visible status is nonzero.
- GAP: the settling window after a read.

Its transitions are:
- IDLE→HOLD on an event.
- IDLE→GAP, HOLD→GAP and GAP→GAP on a read. In GAP the read restarts the window.
- GAP→HOLD when the window ends and something is pending.
- GAP→IDLE when the window ends and nothing is pending.

Top module: `stacked_irq_status`

## Requirements
- R1: During and right after reset the status word reads 0x00 and `irq_o` is low.
- R2: Status bit positions are fixed. Bit 6 is function complete (`cond_i[6]`), bit 5 selected, bit 4 reselected, bit 3 gross error, bit 2 unexpected disconnect, bit 1 bus reset and bit 0 parity error, each taken from `cond_i[n]` into bit n.
- R3: Bit 7 is set by `phase_mis_i` when `tgt_mode_i` is 0 and by `atn_i` when `tgt_mode_i` is 1. The unselected input has no effect.
- R4: Status bits latch whether or not the matching `irq_en_i` bit is set.
- R5: `irq_o` is high exactly when some status bit and its enable bit are both 1. It follows `irq_en_i` in the same cycle.
- R6: `rd_data_o` shows the current status word. A set bit stays set until a cycle with `rd_i` high, and on the next cycle every bit that was shown reads 0.
- R7: In IDLE, an event appears in the status word on the next cycle.
- R8: An event arriving while the status word is nonzero goes to the pending level. A repeat of an already pending condition merges into the same pending bit.
- R9: An event on the same cycle as a read goes to the pending level and is not lost.
- R10: After a read, the status word reads 0 for 12 cycles. Pending bits, together with any event in the 12th cycle, appear on the 13th cycle after the read edge, and the pending level then empties.
- R11: A read during the gap restarts the 12-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_mode_i | input | 1 | 0 selects initiator meaning for bit 7, 1 selects target meaning |
| phase_mis_i | input | 1 | Phase-mismatch pulse, strobed at REQ |
| atn_i | input | 1 | ATN-asserted pulse |
| cond_i | input | 7 | Event pulses for status bits 6..0 |
| rd_i | input | 1 | Read strobe; clears shown bits |
| irq_en_i | input | 8 | Interrupt enable mask |
| rd_data_o | output | 8 | Visible status word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Three kinds of wrong internal state show up at the ports.

A lost or wrongly merged pending bit shows on the first read after the gap, 13 cycles after the clearing read. At that point the promoted word differs from what the bench model expects.

A wrong state or gap counter shows up on the cycle it happens, in one of two ways. Promotion can come one cycle early or late, visible as a nonzero `rd_data_o` inside the window. Or an event can be routed to the wrong level, so the next word reads wrong.

Mask or bit-7 routing errors show at once on `irq_o` or on bit 7 of `rd_data_o`.

// File: rtl/stacked_irq_pkg.sv
package stacked_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_GAP  = 2'd2
    } irq_st_e;
endpackage

// File: rtl/stacked_irq_src_mux.sv
module stacked_irq_src_mux #(
    parameter int W = 8
) (
    input  logic         tgt_mode_i,
    input  logic         phase_mis_i,
    input  logic         atn_i,
    input  logic [W-2:0] cond_i,
    output logic [W-1:0] evt_o
);
    logic top_bit;

    always_comb begin
        top_bit = tgt_mode_i ? atn_i : phase_mis_i;
        evt_o   = {top_bit, cond_i};
    end
endmodule

// File: rtl/stacked_irq_gap_timer.sv
module stacked_irq_gap_timer #(
    parameter int GAP_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= LOAD;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R11
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cnt_q == LOAD);
endmodule

// File: rtl/stacked_irq_fsm.sv
module stacked_irq_fsm
    import stacked_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_i,
    input  logic         gap_done_i,
    output logic [W-1:0] status_o,
    output logic         gap_start_o,
    output logic         gap_run_o
);
    irq_st_e        state_q, state_d;
    logic [W-1:0]   stat_q, stat_d;
    logic [W-1:0]   pend_q, pend_d;
    logic [W-1:0]   merged;

    // state register and data levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stat_q  <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
            pend_q  <= pend_d;
        end
    end

    // next state and level updates
    always_comb begin
        merged      = pend_q | evt_i;
        state_d     = state_q;
        stat_d      = stat_q;
        pend_d      = pend_q;
        gap_start_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_i) begin
                    pend_d      = merged;
                    gap_start_o = 1'b1;
                    state_d     = ST_GAP;
                end else if (evt_i != '0) begin
                    stat_d  = evt_i;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                pend_d = merged;
                if (rd_i) begin
                    stat_d      = '0;
                    gap_start_o = 1'b1;
                    state_d     = ST_GAP;
                end
            end
            ST_GAP: begin
                if (rd_i) begin
                    pend_d      = merged;
                    gap_start_o = 1'b1;
                end else if (gap_done_i) begin
                    stat_d  = merged;
                    pend_d  = '0;
                    state_d = (merged != '0) ? ST_HOLD : ST_IDLE;
                end else begin
                    pend_d = merged;
                end
            end
            default: begin
                state_d = ST_IDLE;
                stat_d  = '0;
                pend_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        status_o  = stat_q;
        gap_run_o = (state_q == ST_GAP);
    end

    // R10
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_GAP |-> stat_q == '0);

    // R7
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> (stat_q == '0 && pend_q == '0));

    // R8
    hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD |-> stat_q != '0);

    // R9
    read_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (pend_q & $past(evt_i)) == $past(evt_i));
endmodule

// File: rtl/stacked_irq_status.sv
module stacked_irq_status #(
    parameter int W       = 8,
    parameter int GAP_CYC = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tgt_mode_i,
    input  logic         phase_mis_i,
    input  logic         atn_i,
    input  logic [W-2:0] cond_i,
    input  logic         rd_i,
    input  logic [W-1:0] irq_en_i,
    output logic [W-1:0] rd_data_o,
    output logic         irq_o
);
    logic [W-1:0] evt;
    logic [W-1:0] status;
    logic         gap_start, gap_run, gap_done;

    stacked_irq_src_mux #(.W(W)) u_mux (
        .tgt_mode_i (tgt_mode_i),
        .phase_mis_i(phase_mis_i),
        .atn_i      (atn_i),
        .cond_i     (cond_i),
        .evt_o      (evt)
    );

    stacked_irq_gap_timer #(.GAP_CYC(GAP_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(gap_start),
        .run_i  (gap_run),
        .done_o (gap_done)
    );

    stacked_irq_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .rd_i       (rd_i),
        .gap_done_i (gap_done),
        .status_o   (status),
        .gap_start_o(gap_start),
        .gap_run_o  (gap_run)
    );

    assign rd_data_o = status;
    assign irq_o     = |(status & irq_en_i);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rd_data_o == '0);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (rd_data_o & $past(rd_data_o)) == $past(rd_data_o));

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rd_data_o != '0);
endmodule

// File: tb/stacked_irq_status_tb.sv
module stacked_irq_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tgt_mode_i = 1'b0;
    logic       phase_mis_i = 1'b0;
    logic       atn_i = 1'b0;
    logic [6:0] cond_i = '0;
    logic       rd_i = 1'b0;
    logic [7:0] irq_en_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_s = '0;
    logic [7:0] m_p = '0;
    bit         m_gap = 1'b0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    stacked_irq_status u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt_mode_i (tgt_mode_i),
        .phase_mis_i(phase_mis_i),
        .atn_i      (atn_i),
        .cond_i     (cond_i),
        .rd_i       (rd_i),
        .irq_en_i   (irq_en_i),
        .rd_data_o  (rd_data_o),
        .irq_o      (irq_o)
    );

    function automatic logic [7:0] evt_of(logic md, logic pm, logic at, logic [6:0] c);
        return {(md ? at : pm), c};
    endfunction

    function automatic logic irq_of(logic [7:0] s, logic [7:0] en);
        return |(s & en);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(logic [7:0] ev, logic rd);
        if (rd) begin
            m_s = '0; m_p |= ev; m_gap = 1'b1; m_cnt = 11;
        end else if (m_gap) begin
            if (m_cnt == 0) begin
                m_s = m_p | ev; m_p = '0; m_gap = 1'b0;
            end else begin
                m_cnt--; m_p |= ev;
            end
        end else if (m_s == '0) begin
            m_s = ev;
        end else begin
            m_p |= ev;
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(logic [6:0] c, logic pm, logic at, logic rd);
        logic [7:0] ev;
        cond_i = c; phase_mis_i = pm; atn_i = at; rd_i = rd;
        ev = evt_of(tgt_mode_i, pm, at, c);
        @(posedge clk);
        model_step(ev, rd);
        @(negedge clk);
        chk("R6 status vs model", rd_data_o, m_s);
        chk("R5 irq vs model", irq_o, irq_of(m_s, irq_en_i));
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, 1'b0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset status", rd_data_o, 8'h00);
        chk("R1 reset irq", irq_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", rd_data_o, 8'h00);

        // R2 R4 R7: parity and gross error latch next cycle, mask clear
        irq_en_i = 8'h00;
        cyc(7'h09, 1'b0, 1'b0, 1'b0);
        chk("R2 R7 bits 3 and 0", rd_data_o, 8'h09);
        chk("R4 no irq with mask 0", irq_o, 1'b0);
        // R5 same-cycle enable
        irq_en_i = 8'h08; #1;
        chk("R5 irq follows enable", irq_o, 1'b1);
        // R8 stack + merge while held
        cyc(7'h40, 1'b0, 1'b0, 1'b0);
        cyc(7'h40, 1'b0, 1'b0, 1'b0);
        chk("R8 held word unchanged", rd_data_o, 8'h09);
        // read, with an event on the same cycle (R9)
        cyc(7'h02, 1'b0, 1'b0, 1'b1);
        chk("R6 cleared after read", rd_data_o, 8'h00);
        idle_n(11);
        chk("R10 still zero at 12th cycle", rd_data_o, 8'h00);
        idle_n(1);
        chk("R9 R10 promoted word", rd_data_o, 8'h42);
        // R11 restart gap
        cyc('0, 1'b0, 1'b0, 1'b1);
        cyc(7'h10, 1'b0, 1'b0, 1'b0);
        idle_n(5);
        cyc('0, 1'b0, 1'b0, 1'b1);
        idle_n(11);
        chk("R11 restarted window zero", rd_data_o, 8'h00);
        idle_n(1);
        chk("R11 promoted after restart", rd_data_o, 8'h10);
        cyc('0, 1'b0, 1'b0, 1'b1);
        idle_n(13);
        // R3 initiator mode: ATN ignored, mismatch sets bit 7
        tgt_mode_i = 1'b0;
        cyc('0, 1'b0, 1'b1, 1'b0);
        chk("R3 atn ignored in initiator", rd_data_o, 8'h00);
        cyc('0, 1'b1, 1'b0, 1'b0);
        chk("R3 mismatch bit7", rd_data_o, 8'h80);
        cyc('0, 1'b0, 1'b0, 1'b1);
        idle_n(13);
        // R3 target mode
        tgt_mode_i = 1'b1;
        cyc('0, 1'b1, 1'b0, 1'b0);
        chk("R3 mismatch ignored in target", rd_data_o, 8'h00);
        cyc('0, 1'b0, 1'b1, 1'b0);
        chk("R3 atn bit7", rd_data_o, 8'h80);
        irq_en_i = 8'h80; #1;
        chk("R5 irq bit7", irq_o, 1'b1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] c;
            logic pm, at, rd;
            c  = ($urandom % 4 == 0) ? 7'($urandom) : 7'h00;
            pm = ($urandom % 8 == 0);
            at = ($urandom % 8 == 0);
            rd = ($urandom % 9 == 0);
            if ($urandom % 50 == 0) tgt_mode_i = ~tgt_mode_i;
            if ($urandom % 20 == 0) irq_en_i = 8'($urandom);
            cyc(c, pm, at, rd);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule